// File: doc/BRIEF.md
# Extended-Precision Floating-Point Adder

This unit adds two extended-precision floating-point numbers. Each number has a 40-bit two's-complement mantissa and an 8-bit two's-complement exponent. The mantissa is a sign bit followed by 39 fraction bits. The two operands are called the accumulator and the operand. A one-cycle start pulse presents them. The unit brings both to the larger exponent, adds the mantissas and corrects a mantissa carry-out. It saturates when the exponent overflows. Otherwise it normalizes the sum one bit per clock and flushes the result to zero on exponent underflow. A one-cycle done pulse marks the end of the operation. The result comes with an overflow interrupt flag, an underflow interrupt flag and a one-hot condition status.

The surrounding execution unit supplies the operands, usually taken from a register triple and a memory operand, and writes the result back. Latency depends on the data. It is two clocks when no normalization shift is needed and at most 41 clocks. Result and flags hold their values from done until the next accepted start.

Top module: `xfp_add_engine`

## Requirements
- R1: The operand with the smaller exponent has its mantissa shifted right arithmetically by the exponent difference, and the larger exponent is carried forward. A difference of 40 or more leaves that mantissa as all copies of its sign bit.
- R2: When the accumulator mantissa is zero, the operand's exponent and unshifted mantissa form the sum. When the accumulator has the smaller exponent but the operand mantissa is zero, nothing is shifted and the accumulator exponent is kept.
- R3: When the 40-bit mantissa sum overflows, the sum is shifted right by one with the true sign restored in bit 39, and the exponent is incremented by one.
- R4: If that increment gives an exponent of 0x7F or more, `ovf_irq` is set and `res_exp` becomes 0x7F. `res_mant` becomes 0x7FFFFFFFFF when the sum is positive and 0x8000000000 when it is negative.
- R5: A nonzero result without overflow is shifted left until bits 39 and 38 of `res_mant` differ. The exponent is decremented once per shift.
- R6: If a normalization shift would take the exponent below 0x80 (−128), `unf_irq` is set and the result is mantissa 0, exponent 0.
- R7: A zero mantissa sum gives `res_mant` = 0 and `res_exp` = 0, with `unf_irq` clear.
- R8: `cond` is 4'b0010 for a zero result, 4'b0001 for a negative result and 4'b0100 for a positive nonzero result. After reset it reads 4'b0010.
- R9: `done` is high for exactly one clock per operation. Both flags read 0 in the clock after a start is accepted. Result, flags and `cond` stay unchanged from `done` until the next accepted start. After reset all outputs are zero apart from `cond`.
- R10: A `start` that arrives while an operation is still in progress is ignored. It produces neither a result nor a done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches an addition |
| acc_mant | input | 40 | Accumulator mantissa, two's complement |
| acc_exp | input | 8 | Accumulator exponent, two's complement |
| opd_mant | input | 40 | Operand mantissa, two's complement |
| opd_exp | input | 8 | Operand exponent, two's complement |
| done | output | 1 | One-cycle pulse: result valid |
| res_mant | output | 40 | Result mantissa |
| res_exp | output | 8 | Result exponent |
| ovf_irq | output | 1 | Exponent overflow, result saturated |
| unf_irq | output | 1 | Exponent underflow, result flushed to zero |
| cond | output | 4 | One-hot condition status of the result |

## Verification
The bench targets the following corner cases:
- **Exponent gaps of 40 or more with a negative operand.** A shifter that clears to zero instead of filling with the sign produces a value off by one least-significant step.
- **Mantissa carry-out with both operands at the most negative mantissa.** A design that does not invert the top bit after the shift returns a positive mantissa.
- **Exponents of 0x7E and 0x7F before the increment.** These separate a saturating design from one that wraps the exponent or picks the wrong saturation sign.
- **Normalization from a single set bit and from −1.** These take the longest shift chains.
- **Exponents at exactly −128 and one above it.** These show whether underflow fires one shift early or one shift late.
- **A second start during a long normalization.** A design that re-accepts it produces an extra done pulse.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

    localparam int MANT_W = 40;
    localparam int EXP_W  = 8;
    localparam int DIFF_W = EXP_W + 1;

    typedef logic signed [MANT_W-1:0] mant_t;
    typedef logic signed [EXP_W-1:0]  exp_t;
    typedef logic signed [DIFF_W-1:0] dexp_t;

    typedef struct packed {
        mant_t m;
        exp_t  e;
    } xfp_t;

    // Output of the align/add stage, ready for normalization
    typedef struct packed {
        mant_t m;
        exp_t  e;
        logic  sat;   // exponent overflow, m/e already saturated
        logic  zero;  // mantissa sum is exactly zero
    } addsum_t;

    typedef enum logic [3:0] {
        CS_NEG  = 4'b0001,
        CS_ZERO = 4'b0010,
        CS_POS  = 4'b0100
    } cstat_e;

    typedef enum logic {
        ST_IDLE,
        ST_SHIFT
    } nstate_e;

    localparam exp_t  EXP_TOP      = {1'b0, {(EXP_W-1){1'b1}}};
    localparam exp_t  EXP_BOT      = {1'b1, {(EXP_W-1){1'b0}}};
    localparam mant_t MANT_POS_SAT = {1'b0, {(MANT_W-1){1'b1}}};
    localparam mant_t MANT_NEG_SAT = {1'b1, {(MANT_W-1){1'b0}}};

    // Arithmetic right shift that collapses to sign fill for large counts
    function automatic mant_t sar_sat(input mant_t v, input logic [DIFF_W-1:0] n);
        if (n >= DIFF_W'(MANT_W)) begin
            return {MANT_W{v[MANT_W-1]}};
        end
        return v >>> n;
    endfunction

    function automatic cstat_e classify(input mant_t m);
        if (m == '0) begin
            return CS_ZERO;
        end
        if (m[MANT_W-1]) begin
            return CS_NEG;
        end
        return CS_POS;
    endfunction

endpackage

// File: rtl/xfp_align.sv
module xfp_align
    import xfp_pkg::*;
(
    input  xfp_t    acc_i,
    input  xfp_t    opd_i,
    output addsum_t sum_o
);

    dexp_t             diff;
    dexp_t             ndiff;
    mant_t             ma;
    mant_t             mb;
    exp_t              ebase;
    logic [MANT_W:0]   raw;
    logic              mant_ovf;
    dexp_t             einc;

    // Exponent comparison and alignment of the smaller operand
    always_comb begin
        diff  = {acc_i.e[EXP_W-1], acc_i.e} - {opd_i.e[EXP_W-1], opd_i.e};
        ndiff = -diff;
        if (acc_i.m == '0) begin
            ma    = '0;
            mb    = opd_i.m;
            ebase = opd_i.e;
        end else if (!diff[DIFF_W-1]) begin
            ma    = acc_i.m;
            mb    = sar_sat(opd_i.m, diff);
            ebase = acc_i.e;
        end else if (opd_i.m != '0) begin
            ma    = sar_sat(acc_i.m, ndiff);
            mb    = opd_i.m;
            ebase = opd_i.e;
        end else begin
            ma    = acc_i.m;
            mb    = '0;
            ebase = acc_i.e;
        end
    end

    // Add with one guard bit, then carry-out correction and saturation
    always_comb begin
        raw      = {ma[MANT_W-1], ma} + {mb[MANT_W-1], mb};
        mant_ovf = raw[MANT_W] ^ raw[MANT_W-1];
        einc     = {ebase[EXP_W-1], ebase} + DIFF_W'(1);

        sum_o.m    = raw[MANT_W-1:0];
        sum_o.e    = ebase;
        sum_o.sat  = 1'b0;
        sum_o.zero = 1'b0;

        if (mant_ovf) begin
            if (einc >= dexp_t'(EXP_TOP)) begin
                sum_o.sat = 1'b1;
                sum_o.e   = EXP_TOP;
                sum_o.m   = raw[MANT_W] ? MANT_NEG_SAT : MANT_POS_SAT;
            end else begin
                sum_o.m = raw[MANT_W:1];
                sum_o.e = einc[EXP_W-1:0];
            end
        end else begin
            sum_o.zero = (raw[MANT_W-1:0] == '0);
        end
    end

endmodule

// File: rtl/xfp_norm.sv
module xfp_norm
    import xfp_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  addsum_t sum_i,
    output xfp_t    res_o,
    output logic    ovf_o,
    output logic    unf_o,
    output logic    done_o
);

    nstate_e state;
    mant_t   wm;
    exp_t    we;
    logic    wsat;
    logic    wzero;
    logic    is_norm;

    assign is_norm = wm[MANT_W-1] ^ wm[MANT_W-2];

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            wm     <= '0;
            we     <= '0;
            wsat   <= 1'b0;
            wzero  <= 1'b0;
            res_o  <= '0;
            ovf_o  <= 1'b0;
            unf_o  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_i) begin
                        wm    <= sum_i.m;
                        we    <= sum_i.e;
                        wsat  <= sum_i.sat;
                        wzero <= sum_i.zero;
                        ovf_o <= 1'b0;
                        unf_o <= 1'b0;
                        state <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (wsat) begin
                        res_o.m <= wm;
                        res_o.e <= we;
                        ovf_o   <= 1'b1;
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (wzero) begin
                        res_o   <= '0;
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (is_norm) begin
                        res_o.m <= wm;
                        res_o.e <= we;
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (we == EXP_BOT) begin
                        res_o   <= '0;
                        unf_o   <= 1'b1;
                        done_o  <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        wm <= {wm[MANT_W-2:0], 1'b0};
                        we <= we - exp_t'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_SAT_LIMITS: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o) |-> (res_o.e == EXP_TOP &&
            (res_o.m == MANT_POS_SAT || res_o.m == MANT_NEG_SAT))); // R4

    AST_UNF_FLUSH: assert property (@(posedge clk) disable iff (rst)
        (done_o && unf_o) |-> (res_o.m == '0 && res_o.e == '0)); // R6

    AST_NORM_FORM: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o && res_o.m != '0) |->
            (res_o.m[MANT_W-1] != res_o.m[MANT_W-2])); // R5

    AST_ZERO_EXP: assert property (@(posedge clk) disable iff (rst)
        (done_o && res_o.m == '0) |-> (res_o.e == '0 && !ovf_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R9

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !start_i) |=>
            ($stable(res_o) && $stable(ovf_o) && $stable(unf_o))); // R9

    AST_START_CLR: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_i) |=>
            (state == ST_SHIFT && !ovf_o && !unf_o && !done_o)); // R9

    AST_BUSY_NODONE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && $past(state) == ST_SHIFT) |-> !done_o); // R10

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o)); // R6

endmodule

// File: rtl/xfp_status.sv
module xfp_status
    import xfp_pkg::*;
(
    input  mant_t      mant_i,
    output logic [3:0] cs_o
);

    cstat_e cs;

    always_comb begin
        cs   = classify(mant_i);
        cs_o = cs;
    end

endmodule

// File: rtl/xfp_add_engine.sv
module xfp_add_engine
    import xfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [MANT_W-1:0] acc_mant,
    input  logic [EXP_W-1:0]  acc_exp,
    input  logic [MANT_W-1:0] opd_mant,
    input  logic [EXP_W-1:0]  opd_exp,
    output logic              done,
    output logic [MANT_W-1:0] res_mant,
    output logic [EXP_W-1:0]  res_exp,
    output logic              ovf_irq,
    output logic              unf_irq,
    output logic [3:0]        cond
);

    xfp_t    acc_w;
    xfp_t    opd_w;
    addsum_t sum_w;
    xfp_t    res_w;

    assign acc_w = {acc_mant, acc_exp};
    assign opd_w = {opd_mant, opd_exp};

    xfp_align u_align (
        .acc_i (acc_w),
        .opd_i (opd_w),
        .sum_o (sum_w)
    );

    xfp_norm u_norm (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .sum_i   (sum_w),
        .res_o   (res_w),
        .ovf_o   (ovf_irq),
        .unf_o   (unf_irq),
        .done_o  (done)
    );

    xfp_status u_status (
        .mant_i (res_w.m),
        .cs_o   (cond)
    );

    assign res_mant = res_w.m;
    assign res_exp  = res_w.e;

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones(cond) == 1); // R8

endmodule

// File: tb/xfp_add_engine_test.sv
`timescale 1ns/1ps
module xfp_add_engine_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [39:0] acc_mant = '0;
    logic [7:0]  acc_exp = '0;
    logic [39:0] opd_mant = '0;
    logic [7:0]  opd_exp = '0;
    logic        done;
    logic [39:0] res_mant;
    logic [7:0]  res_exp;
    logic        ovf_irq;
    logic        unf_irq;
    logic [3:0]  cond;

    always #2 clk = ~clk;

    xfp_add_engine uut (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .acc_mant (acc_mant),
        .acc_exp  (acc_exp),
        .opd_mant (opd_mant),
        .opd_exp  (opd_exp),
        .done     (done),
        .res_mant (res_mant),
        .res_exp  (res_exp),
        .ovf_irq  (ovf_irq),
        .unf_irq  (unf_irq),
        .cond     (cond)
    );

    typedef struct {
        logic [39:0] m;
        logic [7:0]  e;
        logic        ovf;
        logic        unf;
        logic [3:0]  cs;
        string       req;
    } exp_item_t;

    exp_item_t sb[$];
    exp_item_t last_item;
    int nvec  = 0;
    int nfail = 0;
    int ndone = 0;

    localparam longint LIM  = 64'sd549755813888;  // 2^39
    localparam longint HALF = 64'sd274877906944;  // 2^38

    // Reference model of the requirements, in 64-bit integer arithmetic
    function automatic exp_item_t ref_add(input logic [39:0] am, input logic [7:0] ae,
                                          input logic [39:0] bm, input logic [7:0] be,
                                          input string req);
        exp_item_t it;
        longint a, b, s;
        int ea, eb, e, d;
        a  = longint'($signed(am));
        b  = longint'($signed(bm));
        ea = int'($signed(ae));
        eb = int'($signed(be));
        it.ovf = 1'b0;
        it.unf = 1'b0;
        if (a == 0) begin
            e = eb;
            s = b;
        end else if (ea >= eb) begin
            d = ea - eb;
            if (d > 63) d = 63;
            s = a + (b >>> d);
            e = ea;
        end else if (b != 0) begin
            d = eb - ea;
            if (d > 63) d = 63;
            s = (a >>> d) + b;
            e = eb;
        end else begin
            s = a;
            e = ea;
        end
        if (s >= LIM || s < -LIM) begin
            s = s >>> 1;
            e = e + 1;
            if (e >= 127) begin
                it.ovf = 1'b1;
                e = 127;
                s = (s < 0) ? -LIM : LIM - 1;
            end
        end else if (s == 0) begin
            e = 0;
        end else begin
            while (s < HALF && s >= -HALF) begin
                if (e == -128) begin
                    it.unf = 1'b1;
                    s = 0;
                    e = 0;
                    break;
                end
                s = s <<< 1;
                e = e - 1;
            end
        end
        it.m   = s[39:0];
        it.e   = e[7:0];
        it.cs  = (s == 0) ? 4'b0010 : ((s < 0) ? 4'b0001 : 4'b0100);
        it.req = req;
        return it;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        nvec++;
        if (act !== expv) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Monitor: pops the scoreboard on every done pulse
    always @(negedge clk) begin
        if (!rst && done) begin
            exp_item_t it;
            ndone++;
            if (sb.size() == 0) begin
                nvec++;
                nfail++;
                $display("FAIL R10 unexpected done: actual m=%h e=%h expected no result",
                         res_mant, res_exp);
            end else begin
                it = sb.pop_front();
                last_item = it;
                nvec++;
                if (res_mant !== it.m || res_exp !== it.e || ovf_irq !== it.ovf ||
                    unf_irq !== it.unf || cond !== it.cs) begin
                    nfail++;
                    $display("FAIL %s: actual m=%h e=%h ovf=%b unf=%b cs=%b expected m=%h e=%h ovf=%b unf=%b cs=%b",
                             it.req, res_mant, res_exp, ovf_irq, unf_irq, cond,
                             it.m, it.e, it.ovf, it.unf, it.cs);
                end
            end
        end
    end

    task automatic wait_idle();
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Driver: pushes the expected item, pulses start, checks flag clearing
    task automatic run_op(input logic [39:0] am, input logic [7:0] ae,
                          input logic [39:0] bm, input logic [7:0] be, input string req);
        sb.push_back(ref_add(am, ae, bm, be, req));
        @(negedge clk);
        acc_mant = am;
        acc_exp  = ae;
        opd_mant = bm;
        opd_exp  = be;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R9", "flags cleared after start", {62'd0, ovf_irq, unf_irq}, 64'd0);
        wait_idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL R9 watchdog expired: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        int done_before;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "reset done",   {63'd0, done}, 64'd0);
        check("R9", "reset flags",  {62'd0, ovf_irq, unf_irq}, 64'd0);
        check("R9", "reset result", {16'd0, res_mant, res_exp}, 64'd0);
        check("R8", "reset cond",   {60'd0, cond}, 64'd2);

        // R1: alignment
        run_op(40'h2000000000, 8'd2, 40'h2000000000, 8'd0, "R1 opd shifted");
        run_op(40'h2000000000, 8'hFB, 40'h3000000000, 8'd3, "R1 acc shifted");
        run_op(40'h4000000000, 8'd50, 40'h8000000000, 8'd0, "R1 gap>=40 negative fill");
        run_op(40'h4000000000, 8'd40, 40'h7FFFFFFFFF, 8'd0, "R1 gap=40 positive");
        run_op(40'hC000000000, 8'd0, 40'h4000000000, 8'd39, "R1 gap=39");
        // R2: zero mantissas
        run_op(40'h0000000000, 8'd10, 40'h6000000000, 8'hEC, "R2 zero accumulator");
        run_op(40'h4000000000, 8'hFD, 40'h0000000000, 8'd20, "R2 zero operand");
        // R3: mantissa carry-out
        run_op(40'h6000000000, 8'd5, 40'h6000000000, 8'd5, "R3 positive carry");
        run_op(40'h8000000000, 8'd0, 40'h8000000000, 8'd0, "R3 negative carry");
        run_op(40'h7FFFFFFFFF, 8'd125, 40'h7FFFFFFFFF, 8'd125, "R3 exp 126 no ovf");
        // R4: exponent overflow
        run_op(40'h6000000000, 8'd126, 40'h6000000000, 8'd126, "R4 positive sat");
        run_op(40'h8000000000, 8'd127, 40'h8000000000, 8'd127, "R4 negative sat");
        // R9: flags cleared by next start, result held after done
        run_op(40'h4000000000, 8'd1, 40'h0000000000, 8'd0, "R9 after overflow");
        repeat (4) @(negedge clk);
        check("R9", "held mantissa", {24'd0, res_mant}, {24'd0, last_item.m});
        check("R9", "held exponent", {56'd0, res_exp}, {56'd0, last_item.e});
        check("R9", "held cond", {60'd0, cond}, {60'd0, last_item.cs});
        check("R9", "single done pulse", {63'd0, done}, 64'd0);
        // R5: normalization
        run_op(40'h0000000001, 8'd0, 40'h0000000000, 8'd0, "R5 single bit");
        run_op(40'hFFFFFFFFFF, 8'd0, 40'h0000000000, 8'd0, "R5 minus one");
        run_op(40'hC000000000, 8'd4, 40'h0000000000, 8'd0, "R5 negative half");
        run_op(40'h2000000000, 8'h81, 40'h0000000000, 8'd0, "R5 reach -128 exactly");
        // R6: underflow
        run_op(40'h2000000000, 8'h80, 40'h0000000000, 8'h80, "R6 at -128");
        run_op(40'h0000000001, 8'h9C, 40'h0000000000, 8'h9C, "R6 deep underflow");
        // R7: zero sum
        run_op(40'h4000000000, 8'd3, 40'hC000000000, 8'd3, "R7 cancel");
        run_op(40'h0000000000, 8'h80, 40'h0000000000, 8'd7, "R7 both zero");
        // R8: status codes
        run_op(40'hA000000000, 8'd9, 40'h1000000000, 8'd8, "R8 negative result");
        run_op(40'h1000000000, 8'd9, 40'h1000000000, 8'd8, "R8 positive result");

        // R10: start while busy is ignored
        sb.push_back(ref_add(40'h0000000001, 8'd0, 40'h0, 8'd0, "R10 first op"));
        @(negedge clk);
        acc_mant = 40'h0000000001;
        acc_exp  = 8'd0;
        opd_mant = 40'h0;
        opd_exp  = 8'd0;
        start    = 1'b1;
        @(negedge clk);
        acc_mant = 40'h6000000000;
        opd_mant = 40'h6000000000;
        acc_exp  = 8'd126;
        opd_exp  = 8'd126;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        done_before = ndone;
        repeat (50) @(negedge clk);
        check("R10", "no extra done", 64'(ndone), 64'(done_before));
        check("R10", "no overflow from ignored start", {63'd0, ovf_irq}, 64'd0);

        // Mixed random vectors against the model
        for (int k = 0; k < 300; k++) begin
            logic [39:0] am, bm;
            logic [7:0]  ae, be;
            am = 40'({$urandom(), $urandom()});
            bm = 40'({$urandom(), $urandom()});
            if (k % 3 == 0) am = 40'($signed(am) >>> $urandom_range(0, 39));
            if (k % 4 == 1) bm = 40'($signed(bm) >>> $urandom_range(0, 39));
            if (k % 17 == 5) am = '0;
            if (k % 19 == 7) bm = '0;
            ae = 8'($urandom());
            be = (k % 2 == 0) ? 8'(ae + 8'($urandom_range(0, 6)) - 8'd3) : 8'($urandom());
            run_op(am, ae, bm, be, "R1 R3 R5 random");
        end

        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule